// File: doc/BRIEF.md
# Asynchronous Memory Bus Front-End with Byte/Word Mode

This block sits between an asynchronous, strobe-driven memory bus and the synchronous control logic of a memory device. The bus host supplies active-low chip select, output enable, write strobe and a bus-side reset, plus a byte/word mode select, an address and a bidirectional data bus. All strobes, the address and the inbound data are resampled on the system clock through a short synchronizer chain. Write cycles and read cycles are recognised from the resampled copies.

A write cycle is open while chip select and write strobe are both low with output enable high. The address is taken when the cycle opens, which is the later of the two falling strobes. The data is taken when the cycle closes, which is the earlier of the two rising strobes. Each completed write leaves the block as one single-cycle command beat. The beat carries a 21-bit address, the data and a byte flag. In byte mode the top data line is an extra address bit below bit 0, and only the low data byte is significant.

For reads, the block presents a word address to downstream logic. It places the returned word, or one lane of it in byte mode, on the outbound data bus. The outbound bus is driven only during a read. The host must hold every strobe level for at least three system clocks.

Top module: `amem_front`

## Requirements
- R1: After the synchronous reset `rst`, `cmd_valid`, `dq_oe_lo` and `dq_oe_hi` are 0.
- R2: A write cycle (`bus_ce_n`=0 and `bus_we_n`=0 with `bus_oe_n`=1 and `bus_rst_n`=1, strobe levels held at least 3 clocks) produces exactly one `cmd_valid` pulse after it ends.
- R3: The command address is the bus address present when the later of `bus_ce_n` and `bus_we_n` fell. Address changes after that point have no effect.
- R4: The command data is the inbound data present just before the earlier of `bus_ce_n` and `bus_we_n` rose. Data changes after that point have no effect.
- R5: In word mode (`bus_byte_n`=1 at cycle start), `cmd_addr` = {1'b0, `bus_addr`}, `cmd_data` = all 16 bits of `dq_in`, and `cmd_byte`=0.
- R6: In byte mode (`bus_byte_n`=0 at cycle start), `cmd_addr` = {`bus_addr`, `dq_in[15]`}, `cmd_data` = {8'h00, `dq_in[7:0]`}, and `cmd_byte`=1.
- R7: A write strobe with `bus_oe_n`=0 produces no command. So does a cycle during which `bus_oe_n` falls.
- R8: While `bus_rst_n`=0, no command is produced and `dq_oe_lo`/`dq_oe_hi` stay 0. Asserting `bus_rst_n` in the middle of a write cycle cancels that cycle.
- R9: During a word-mode read (`bus_ce_n`=0, `bus_oe_n`=0, `bus_we_n`=1, `bus_rst_n`=1, `bus_byte_n`=1), `rd_addr` equals `bus_addr`, both enables are 1, and `dq_out` equals `rd_data` within 5 clocks.
- R10: During a byte-mode read, only `dq_oe_lo` is 1. `dq_out[7:0]` is `rd_data[15:8]` when `dq_in[15]`=1 and `rd_data[7:0]` when it is 0.
- R11: With `bus_ce_n`=1 (standby), `bus_oe_n`=1, or `bus_we_n`=0, both enables are 0 within 4 clocks.
- R12: `cmd_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Bus chip select, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write strobe, active low |
| bus_rst_n | input | 1 | Bus-side reset, active low |
| bus_byte_n | input | 1 | Mode select: 0 byte, 1 word |
| bus_addr | input | AW (20) | Bus address |
| dq_in | input | DW (16) | Inbound data bus; bit 15 is the byte-address LSB in byte mode |
| dq_out | output | DW (16) | Outbound data bus value |
| dq_oe_lo | output | 1 | Drive enable for dq bits 7:0 |
| dq_oe_hi | output | 1 | Drive enable for dq bits 15:8 |
| cmd_valid | output | 1 | One-cycle command beat |
| cmd_addr | output | AW+1 (21) | Command address |
| cmd_data | output | DW (16) | Command data |
| cmd_byte | output | 1 | Command is a byte write |
| rd_addr | output | AW (20) | Word address presented to read logic |
| rd_data | input | DW (16) | Read data returned by downstream logic |

## Verification
The assertions check on every cycle that a command beat never lasts two cycles. They also check that byte beats carry an empty upper byte and word beats a zero top address bit. Two further per-cycle checks: the upper-lane enable never appears without the lower one, and either enable implies a read condition with bus reset high three clocks earlier. Which address and which data get captured depends on the order of the strobe edges, so only the bench's scenarios can show it. The same holds for the lane picked in byte reads, the suppression of writes with output enable low, and the cancelling of a cycle by the bus reset. The bench drives both falling orders and both rising orders and changes the bus values between edges.

// File: rtl/amem_pkg.sv
package amem_pkg;

  typedef enum logic {
    WR_IDLE  = 1'b0,
    WR_ARMED = 1'b1
  } wr_state_e;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic rst_n;
    logic byte_n;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                      rst_n: 1'b1, byte_n: 1'b1};

  function automatic logic wr_strobe_low(strobe_t s);
    return !s.ce_n && !s.we_n;
  endfunction

  function automatic logic rd_window(strobe_t s);
    return !s.ce_n && !s.oe_n && s.we_n && s.rst_n;
  endfunction

endpackage

// File: rtl/amem_sync.sv
module amem_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/amem_wr_capture.sv
module amem_wr_capture
  import amem_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       s,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_dq,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_byte
);
  localparam int HW = DW / 2;
  localparam int UW = DW - HW;

  wr_state_e     state;
  logic          act, act_q;
  logic [AW:0]   hold_addr;
  logic [DW-1:0] hold_data;
  logic          hold_byte;
  logic [DW-1:0] narrow_dq;

  assign act       = wr_strobe_low(s);
  assign narrow_dq = {{UW{1'b0}}, s_dq[HW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= WR_IDLE;
      act_q     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      hold_byte <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_byte  <= 1'b0;
    end else begin
      act_q     <= act;
      cmd_valid <= 1'b0;
      case (state)
        WR_IDLE: begin
          // cycle opens on the later falling strobe
          if (act && !act_q && s.oe_n && s.rst_n) begin
            state     <= WR_ARMED;
            hold_byte <= !s.byte_n;
            hold_addr <= s.byte_n ? {1'b0, s_addr} : {s_addr, s_dq[DW-1]};
            hold_data <= s.byte_n ? s_dq : narrow_dq;
          end
        end
        WR_ARMED: begin
          if (!s.rst_n || !s.oe_n) begin
            state <= WR_IDLE;
          end else if (act) begin
            hold_data <= hold_byte ? narrow_dq : s_dq;
          end else begin
            // earliest rising strobe closes the cycle; data is last active sample
            state     <= WR_IDLE;
            cmd_valid <= 1'b1;
            cmd_addr  <= hold_addr;
            cmd_data  <= hold_data;
            cmd_byte  <= hold_byte;
          end
        end
        default: state <= WR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amem_rd_drive.sv
module amem_rd_drive
  import amem_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       s,
  input  logic [AW-1:0] s_addr,
  input  logic          s_lsb,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe_lo,
  output logic          dq_oe_hi
);
  localparam int HW = DW / 2;

  logic          drive;
  logic [DW-1:0] byte_lane;

  assign drive     = rd_window(s);
  assign byte_lane = {rd_data[DW-1:HW],
                      s_lsb ? rd_data[DW-1:HW] : rd_data[HW-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr  <= '0;
      dq_out   <= '0;
      dq_oe_lo <= 1'b0;
      dq_oe_hi <= 1'b0;
    end else begin
      rd_addr  <= s_addr;
      dq_out   <= s.byte_n ? rd_data : byte_lane;
      dq_oe_lo <= drive;
      dq_oe_hi <= drive && s.byte_n;
    end
  end
endmodule

// File: rtl/amem_front.sv
module amem_front
  import amem_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_ce_n,
  input  logic          bus_oe_n,
  input  logic          bus_we_n,
  input  logic          bus_rst_n,
  input  logic          bus_byte_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe_lo,
  output logic          dq_oe_hi,
  output logic          cmd_valid,
  output logic [AW:0]   cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_byte,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int SW = $bits(strobe_t);
  localparam int BW = AW + DW;

  strobe_t       raw_s, s;
  logic [SW-1:0] s_bits;
  logic [BW-1:0] bus_q;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_dq;

  assign raw_s = '{ce_n: bus_ce_n, oe_n: bus_oe_n, we_n: bus_we_n,
                   rst_n: bus_rst_n, byte_n: bus_byte_n};

  amem_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) u_sync_strobe (
    .clk(clk), .rst(rst), .d(raw_s), .q(s_bits)
  );

  // address and data take the same path length as the strobes
  amem_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk(clk), .rst(rst), .d({bus_addr, dq_in}), .q(bus_q)
  );

  assign s      = strobe_t'(s_bits);
  assign s_addr = bus_q[BW-1:DW];
  assign s_dq   = bus_q[DW-1:0];

  amem_wr_capture #(.AW(AW), .DW(DW)) u_wr (
    .clk(clk), .rst(rst), .s(s), .s_addr(s_addr), .s_dq(s_dq),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .cmd_byte(cmd_byte)
  );

  amem_rd_drive #(.AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .s(s), .s_addr(s_addr), .s_lsb(s_dq[DW-1]),
    .rd_data(rd_data), .rd_addr(rd_addr), .dq_out(dq_out),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi)
  );
endmodule

// File: rtl/amem_front_chk.sv
module amem_front_chk #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_ce_n,
  input logic          bus_oe_n,
  input logic          bus_we_n,
  input logic          bus_rst_n,
  input logic          dq_oe_lo,
  input logic          dq_oe_hi,
  input logic          cmd_valid,
  input logic [AW:0]   cmd_addr,
  input logic [DW-1:0] cmd_data,
  input logic          cmd_byte
);
  localparam int HW = DW / 2;

  a_r12_single_beat: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte) |-> (cmd_data[DW-1:HW] == '0));

  a_r5_word_addr_top_zero: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_byte) |-> !cmd_addr[AW]);

  a_r10_hi_needs_lo: assert property (@(posedge clk) disable iff (rst)
    dq_oe_hi |-> dq_oe_lo);

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      a_r11_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
        dq_oe_lo |-> $past(!bus_ce_n && !bus_oe_n && bus_we_n, 3));

      a_r8_drive_needs_bus_reset_high: assert property (@(posedge clk) disable iff (rst)
        dq_oe_lo |-> $past(bus_rst_n, 3));
    end
  endgenerate
endmodule

bind amem_front amem_front_chk #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
  .bus_we_n(bus_we_n), .bus_rst_n(bus_rst_n), .dq_oe_lo(dq_oe_lo),
  .dq_oe_hi(dq_oe_hi), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
  .cmd_data(cmd_data), .cmd_byte(cmd_byte)
);

// File: tb/sim_amem_front.sv
module sim_amem_front;
  localparam int AW = 20;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1;
  logic bus_rst_n = 1'b1, bus_byte_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out, rd_data, cmd_data;
  logic dq_oe_lo, dq_oe_hi, cmd_valid, cmd_byte;
  logic [AW:0] cmd_addr;
  logic [AW-1:0] rd_addr;

  always #4 clk = ~clk;

  assign rd_data = rd_addr[15:0] ^ 16'h5A3C;

  amem_front #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_rst_n(bus_rst_n), .bus_byte_n(bus_byte_n),
    .bus_addr(bus_addr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_byte(cmd_byte),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_chk = 0, n_fail = 0;
  int n_cmd = 0;
  bit back2back = 1'b0, prev_v = 1'b0, done = 1'b0;
  logic [AW:0] got_addr;
  logic [DW-1:0] got_data;
  logic got_byte;

  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) begin
        n_cmd++;
        got_addr = cmd_addr;
        got_data = cmd_data;
        got_byte = cmd_byte;
        if (prev_v) back2back = 1'b1;
      end
      prev_v = cmd_valid;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_bus();
    bus_ce_n = 1'b1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
    cyc(8);
  endtask

  // simple write: both strobes fall and rise together
  task automatic plain_write(input logic bn, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_byte_n = bn; bus_addr = a; dq_in = d; bus_oe_n = 1'b1;
    cyc(2);
    bus_ce_n = 1'b0; bus_we_n = 1'b0;
    cyc(6);
    bus_ce_n = 1'b1; bus_we_n = 1'b1;
    cyc(8);
  endtask

  task automatic t_reset();
    cyc(2);
    check("R1 cmd_valid", cmd_valid, 0);
    check("R1 dq_oe_lo", dq_oe_lo, 0);
    check("R1 dq_oe_hi", dq_oe_hi, 0);
  endtask

  task automatic t_word_write();
    int c0 = n_cmd;
    plain_write(1'b1, 20'hABCDE, 16'hC3A7);
    check("R2 one beat word", n_cmd - c0, 1);
    check("R5 word addr", got_addr, {1'b0, 20'hABCDE});
    check("R5 word data", got_data, 16'hC3A7);
    check("R5 word flag", got_byte, 0);
  endtask

  task automatic t_byte_write();
    int c0 = n_cmd;
    plain_write(1'b0, 20'h12345, 16'hFE5B);  // dq15=1 is the address LSB
    check("R2 one beat byte", n_cmd - c0, 1);
    check("R6 byte addr", got_addr, {20'h12345, 1'b1});
    check("R6 byte data", got_data, 16'h005B);
    check("R6 byte flag", got_byte, 1);
    c0 = n_cmd;
    plain_write(1'b0, 20'h00F0F, 16'h7FA1);  // dq15=0
    check("R6 byte addr lsb0", got_addr, {20'h00F0F, 1'b0});
    check("R6 byte data lsb0", got_data, 16'h00A1);
  endtask

  task automatic t_addr_later_fall();
    int c0 = n_cmd;
    bus_byte_n = 1'b1; bus_oe_n = 1'b1;
    bus_addr = 20'h11111; dq_in = 16'h2468;
    cyc(2);
    bus_ce_n = 1'b0; cyc(5);
    bus_addr = 20'h22222; bus_we_n = 1'b0; cyc(5);
    bus_addr = 20'h33333; cyc(5);
    bus_we_n = 1'b1; bus_ce_n = 1'b1; cyc(8);
    check("R3 ce first one beat", n_cmd - c0, 1);
    check("R3 addr at later fall ce first", got_addr, {1'b0, 20'h22222});
    c0 = n_cmd;
    bus_addr = 20'h44444; cyc(2);
    bus_we_n = 1'b0; cyc(5);
    bus_addr = 20'h55555; bus_ce_n = 1'b0; cyc(5);
    bus_addr = 20'h66666; cyc(5);
    idle_bus();
    check("R3 we first one beat", n_cmd - c0, 1);
    check("R3 addr at later fall we first", got_addr, {1'b0, 20'h55555});
  endtask

  task automatic t_data_first_rise();
    int c0 = n_cmd;
    bus_byte_n = 1'b1; bus_oe_n = 1'b1;
    bus_addr = 20'h0A0A0; dq_in = 16'h1111;
    cyc(2);
    bus_ce_n = 1'b0; bus_we_n = 1'b0; cyc(4);
    dq_in = 16'h2222; cyc(4);
    bus_we_n = 1'b1; cyc(5);
    dq_in = 16'h3333; cyc(5);
    bus_ce_n = 1'b1; cyc(8);
    check("R4 we rises first beat", n_cmd - c0, 1);
    check("R4 data at earlier rise we", got_data, 16'h2222);
    c0 = n_cmd;
    dq_in = 16'h4444; cyc(2);
    bus_ce_n = 1'b0; bus_we_n = 1'b0; cyc(5);
    bus_ce_n = 1'b1; cyc(5);
    dq_in = 16'h5555; cyc(5);
    idle_bus();
    check("R4 ce rises first beat", n_cmd - c0, 1);
    check("R4 data at earlier rise ce", got_data, 16'h4444);
  endtask

  task automatic t_oe_low_write();
    int c0 = n_cmd;
    bus_byte_n = 1'b1; bus_addr = 20'h77777; dq_in = 16'h7777;
    bus_oe_n = 1'b0; cyc(2);
    bus_ce_n = 1'b0; bus_we_n = 1'b0; cyc(6);
    check("R11 no drive with we low", dq_oe_lo, 0);
    idle_bus();
    check("R7 oe low no beat", n_cmd - c0, 0);
    c0 = n_cmd;
    bus_ce_n = 1'b0; bus_we_n = 1'b0; cyc(5);
    bus_oe_n = 1'b0; cyc(5);
    idle_bus();
    check("R7 oe falls mid cycle no beat", n_cmd - c0, 0);
  endtask

  task automatic t_bus_reset();
    int c0 = n_cmd;
    bus_rst_n = 1'b0; bus_byte_n = 1'b1; bus_addr = 20'h01234;
    cyc(2);
    bus_ce_n = 1'b0; bus_we_n = 1'b0; cyc(6);
    bus_ce_n = 1'b1; bus_we_n = 1'b1; cyc(8);
    check("R8 no beat in bus reset", n_cmd - c0, 0);
    bus_ce_n = 1'b0; bus_oe_n = 1'b0; cyc(8);
    check("R8 no drive in bus reset", {dq_oe_hi, dq_oe_lo}, 0);
    idle_bus();
    bus_rst_n = 1'b1; cyc(4);
    c0 = n_cmd;
    bus_ce_n = 1'b0; bus_we_n = 1'b0; cyc(5);
    bus_rst_n = 1'b0; cyc(5);
    bus_ce_n = 1'b1; bus_we_n = 1'b1; cyc(5);
    bus_rst_n = 1'b1; cyc(8);
    check("R8 cancelled mid cycle", n_cmd - c0, 0);
  endtask

  task automatic t_word_read();
    logic [15:0] e;
    bus_byte_n = 1'b1; bus_we_n = 1'b1; bus_addr = 20'hBEEF1;
    bus_ce_n = 1'b0; bus_oe_n = 1'b0;
    cyc(6);
    e = 16'hEEF1 ^ 16'h5A3C;
    check("R9 rd_addr", rd_addr, 20'hBEEF1);
    check("R9 enables", {dq_oe_hi, dq_oe_lo}, 2'b11);
    check("R9 dq_out", dq_out, e);
    bus_oe_n = 1'b1; cyc(4);
    check("R11 oe high off", {dq_oe_hi, dq_oe_lo}, 0);
    bus_oe_n = 1'b0; cyc(5);
    bus_ce_n = 1'b1; cyc(4);
    check("R11 standby off", {dq_oe_hi, dq_oe_lo}, 0);
    idle_bus();
  endtask

  task automatic t_byte_read();
    logic [15:0] e;
    bus_byte_n = 1'b0; bus_we_n = 1'b1; bus_addr = 20'h0C0DE;
    e = 16'hC0DE ^ 16'h5A3C;
    dq_in = 16'h8000;
    bus_ce_n = 1'b0; bus_oe_n = 1'b0;
    cyc(6);
    check("R10 enables byte", {dq_oe_hi, dq_oe_lo}, 2'b01);
    check("R10 upper lane", dq_out[7:0], e[15:8]);
    dq_in = 16'h0000; cyc(6);
    check("R10 lower lane", dq_out[7:0], e[7:0]);
    idle_bus();
    bus_byte_n = 1'b1;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_reset();
    t_word_write();
    t_byte_write();
    t_addr_later_fall();
    t_data_first_rise();
    t_oe_low_write();
    t_bus_reset();
    t_word_read();
    t_byte_read();
    check("R12 no back to back beat", back2back, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule